// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping for a processor's circular register-window file using occupancy counts instead of a per-window mask. Four counters track how many windows can still be entered by a save (`cansave`), how many can be returned to by a restore (`canrestore`), how many hold zeroed contents (`cleanwin`) and how many belong to another context (`otherwin`). Next to these sit a 6-bit window-state register and the current window pointer.

Each clock the block accepts at most one request on `req_op`, qualified by `req_valid`. A request either moves the counters and the pointer, or leaves every piece of state unchanged and raises a trap. The trap is reported one cycle later as a pulse on `trap_valid` together with a 9-bit trap number. Spill and fill trap numbers are formed from the window-state fields, and the field used depends on whether `otherwin` is zero. Software sees the window pointer counted in the opposite direction, and writes to it are reduced modulo the window count.

Top module: `wsc_window_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cansave` = N-2, `canrestore` = 0, `otherwin` = 0, `cleanwin` = N-1, `cwp` = 0, `wstate` = 0, `trap_valid` = 0 and `trap_type` = 0 (N = `NWIN`).
- R2: A save (op 0) with `cansave` = 0 raises a spill trap and changes no counter or pointer.
- R3: A save (op 0) with `cansave` nonzero and `cleanwin` equal to `canrestore` raises trap 0x024 and changes no counter or pointer.
- R4: Any other save (op 0) decrements `cansave`, increments `canrestore`, and moves `cwp` down by one, wrapping from 0 to N-1.
- R5: A restore (op 1) with `canrestore` = 0 raises a fill trap and changes nothing. Otherwise it increments `cansave`, decrements `canrestore`, and moves `cwp` up by one, wrapping from N-1 to 0.
- R6: `trap_valid` pulses in the cycle after the trapping request, and `trap_type` is 0 whenever `trap_valid` is 0. A spill number is 0x080 and a fill number is 0x0C0, each ORed with a tail. When `otherwin` is nonzero the tail is 0x020 | (`wstate`[5:3] << 2). Otherwise the tail is `wstate`[2:0] << 2.
- R7: A flush-windows request (op 2) raises a spill trap unless `cansave` = N-2. It never changes any counter or the pointer.
- R8: A saved request (op 3) increments `cansave`. It then decrements `otherwin` if `otherwin` is nonzero, and otherwise decrements `canrestore`.
- R9: A restored request (op 4) increments `canrestore` and increments `cleanwin` only while `cleanwin` < N-1. It then decrements `otherwin` if `otherwin` is nonzero, and otherwise decrements `cansave`.
- R10: `cwp_sw` always equals N-1-`cwp`. A pointer write (op 6) takes `req_data` modulo N as the new `cwp_sw` value.
- R11: Op 5 loads `wstate` from `req_data`[5:0]. Op 7 loads `otherwin` from the low bits of `req_data`. Counter arithmetic wraps at the counter width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request code, 0..7 as listed in the requirements |
| req_data | input | DW | Operand for ops 5, 6 and 7 |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_type | output | 9 | Trap number |
| cwp | output | clog2(NWIN) | Internal window pointer |
| cwp_sw | output | clog2(NWIN) | Pointer as seen by software |
| cansave | output | clog2(NWIN) | Windows available to save |
| canrestore | output | clog2(NWIN) | Windows available to restore |
| cleanwin | output | clog2(NWIN) | Clean window count |
| otherwin | output | clog2(NWIN) | Windows of another context |
| wstate | output | 6 | Window-state register |

## Verification
The bench builds the block twice, once with NWIN = 8 and once with NWIN = 5. The power-of-two build exercises pointer wrap at a natural boundary. The build with 5 windows makes the modulo reduction of software pointer writes and the N-1 wrap non-trivial, because 3-bit counters can then reach values above N-1. In both builds directed sequences drive the counters into the spill, fill and clean-window corners, and a long mixed stream of requests then reaches counter wrap and the `otherwin` trap numbers.

// File: rtl/wsc_pkg.sv
// Shared request codes, trap numbers and trap classes for the window controller.
package wsc_pkg;
    typedef enum logic [2:0] {
        OP_SAVE       = 3'd0,
        OP_RESTORE    = 3'd1,
        OP_FLUSH      = 3'd2,
        OP_SAVED      = 3'd3,
        OP_RESTORED   = 3'd4,
        OP_SET_WSTATE = 3'd5,
        OP_SET_CWP    = 3'd6,
        OP_SET_OTHER  = 3'd7
    } wsc_op_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_SPILL = 2'd1,
        TK_FILL  = 2'd2,
        TK_CLEAN = 2'd3
    } trap_kind_e;

    localparam logic [8:0] TT_SPILL_BASE = 9'h080;
    localparam logic [8:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [8:0] TT_OTHER_FLAG = 9'h020;
    localparam logic [8:0] TT_CLEAN      = 9'h024;
endpackage

// File: rtl/wsc_trap_encode.sv
// Builds the 9-bit trap number from a trap class and the window-state fields.
// Assumes: purely combinational; the caller registers the result.
module wsc_trap_encode
    import wsc_pkg::*;
(
    input  trap_kind_e  kind,
    input  logic        other_nz,
    input  logic [5:0]  wstate,
    output logic [8:0]  ttype
);
    logic [8:0] tail;

    // Pick the window-state field that forms the tail of the trap number.
    always_comb begin
        if (other_nz) tail = TT_OTHER_FLAG | {4'b0, wstate[5:3], 2'b00};
        else          tail = {4'b0, wstate[2:0], 2'b00};
    end

    // Combine the base number of the trap class with the tail.
    always_comb begin
        unique case (kind)
            TK_SPILL: ttype = TT_SPILL_BASE | tail;
            TK_FILL:  ttype = TT_FILL_BASE | tail;
            TK_CLEAN: ttype = TT_CLEAN;
            default:  ttype = 9'h000;
        endcase
    end
endmodule

// File: rtl/wsc_cwp.sv
// Holds the current window pointer: steps it with wrap, loads it from a
// software value reduced modulo NWIN, and presents the reversed view.
// Assumes: at most one of step_down, step_up and load_en is high per cycle.
module wsc_cwp #(
    parameter int NWIN = 8,
    parameter int DW   = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_down,
    input  logic          step_up,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    output logic [CW-1:0] cwp,
    output logic [CW-1:0] cwp_sw
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    logic [CW-1:0] cwp_q;
    logic [DW-1:0] reduced;

    // Reduce the software value into the legal pointer range.
    always_comb reduced = load_val % DW'(NWIN);

    // Update the pointer on a step or a software load.
    always_ff @(posedge clk) begin
        if (!rst_n)         cwp_q <= '0;
        else if (load_en)   cwp_q <= LAST - CW'(reduced);
        else if (step_down) cwp_q <= (cwp_q == '0) ? LAST : cwp_q - CW'(1);
        else if (step_up)   cwp_q <= (cwp_q == LAST) ? '0 : cwp_q + CW'(1);
    end

    assign cwp    = cwp_q;
    assign cwp_sw = LAST - cwp_q;

    p_cwp_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_q <= LAST);
    p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (DW'(cwp_sw) == $past(load_val) % DW'(NWIN)));
    p_step_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_down && !load_en && cwp_q == '0) |=> (cwp_q == LAST));
endmodule

// File: rtl/wsc_occupancy.sv
// Keeps the four window occupancy counters, decides for each request
// whether it moves the counters and pointer or raises a trap, and reports
// the pointer step and the trap class.
// Assumes: NWIN >= 4; counter arithmetic wraps at the counter width.
module wsc_occupancy
    import wsc_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  wsc_op_e       op,
    input  logic [CW-1:0] other_val,
    output logic [CW-1:0] cansave,
    output logic [CW-1:0] canrestore,
    output logic [CW-1:0] cleanwin,
    output logic [CW-1:0] otherwin,
    output trap_kind_e    kind,
    output logic          step_down,
    output logic          step_up
);
    localparam logic [CW-1:0] SAVE_FULL = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_TOP = CW'(NWIN - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    logic [CW-1:0] cs_q, cr_q, cl_q, ow_q;
    logic [CW-1:0] cs_d, cr_d, cl_d, ow_d;

    // Decide the outcome of the request and the next counter values.
    always_comb begin
        cs_d = cs_q; cr_d = cr_q; cl_d = cl_q; ow_d = ow_q;
        kind = TK_NONE; step_down = 1'b0; step_up = 1'b0;
        if (req_valid) begin
            unique case (op)
                OP_SAVE: begin
                    if (cs_q == '0)        kind = TK_SPILL;
                    else if (cl_q == cr_q) kind = TK_CLEAN;
                    else begin
                        cs_d = cs_q - ONE; cr_d = cr_q + ONE; step_down = 1'b1;
                    end
                end
                OP_RESTORE: begin
                    if (cr_q == '0) kind = TK_FILL;
                    else begin
                        cs_d = cs_q + ONE; cr_d = cr_q - ONE; step_up = 1'b1;
                    end
                end
                OP_FLUSH: begin
                    if (cs_q != SAVE_FULL) kind = TK_SPILL;
                end
                OP_SAVED: begin
                    cs_d = cs_q + ONE;
                    if (ow_q != '0) ow_d = ow_q - ONE;
                    else            cr_d = cr_q - ONE;
                end
                OP_RESTORED: begin
                    cr_d = cr_q + ONE;
                    if (cl_q < CLEAN_TOP) cl_d = cl_q + ONE;
                    if (ow_q != '0) ow_d = ow_q - ONE;
                    else            cs_d = cs_q - ONE;
                end
                OP_SET_OTHER: ow_d = other_val;
                default: ;
            endcase
        end
    end

    // Register the counters, loading their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= SAVE_FULL; cr_q <= '0; cl_q <= CLEAN_TOP; ow_q <= '0;
        end else begin
            cs_q <= cs_d; cr_q <= cr_d; cl_q <= cl_d; ow_q <= ow_d;
        end
    end

    assign cansave    = cs_q;
    assign canrestore = cr_q;
    assign cleanwin   = cl_q;
    assign otherwin   = ow_q;

    p_spill_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_SAVE && cs_q == '0)
        |=> ($stable(cs_q) && $stable(cr_q)));
    p_clean_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_SAVE && cs_q != '0 && cl_q == cr_q)
        |=> ($stable(cs_q) && $stable(cr_q) && $stable(cl_q)));
    p_save_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_SAVE && cs_q != '0 && cl_q != cr_q)
        |=> (cs_q == $past(cs_q) - ONE && cr_q == $past(cr_q) + ONE));
    p_flush_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_FLUSH)
        |=> ($stable(cs_q) && $stable(cr_q) && $stable(cl_q) && $stable(ow_q)));
    p_conserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op == OP_SAVED || op == OP_RESTORED))
        |=> (CW'(cs_q + cr_q + ow_q) == CW'($past(cs_q) + $past(cr_q) + $past(ow_q))));
    p_clean_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cl_q <= CLEAN_TOP);
endmodule

// File: rtl/wsc_window_ctrl.sv
// Register window occupancy controller: accepts one request per cycle,
// keeps counters, pointer and window-state, and reports traps one cycle later.
// Assumes: synchronous active-low reset; req_op is meaningful only with req_valid.
module wsc_window_ctrl
    import wsc_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [2:0]              req_op,
    input  logic [DW-1:0]           req_data,
    output logic                    trap_valid,
    output logic [8:0]              trap_type,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic [$clog2(NWIN)-1:0] cwp_sw,
    output logic [$clog2(NWIN)-1:0] cansave,
    output logic [$clog2(NWIN)-1:0] canrestore,
    output logic [$clog2(NWIN)-1:0] cleanwin,
    output logic [$clog2(NWIN)-1:0] otherwin,
    output logic [5:0]              wstate
);
    localparam int CW = $clog2(NWIN);

    wsc_op_e    op;
    trap_kind_e kind;
    logic       step_down, step_up, cwp_load;
    logic [8:0] ttype_d;
    logic [5:0] wstate_q;
    logic       trap_valid_q;
    logic [8:0] trap_type_q;

    assign op       = wsc_op_e'(req_op);
    assign cwp_load = req_valid && (op == OP_SET_CWP);

    wsc_occupancy #(.NWIN(NWIN)) u_occ (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .other_val(req_data[CW-1:0]),
        .cansave(cansave), .canrestore(canrestore),
        .cleanwin(cleanwin), .otherwin(otherwin),
        .kind(kind), .step_down(step_down), .step_up(step_up)
    );

    wsc_cwp #(.NWIN(NWIN), .DW(DW)) u_cwp (
        .clk(clk), .rst_n(rst_n), .step_down(step_down), .step_up(step_up),
        .load_en(cwp_load), .load_val(req_data), .cwp(cwp), .cwp_sw(cwp_sw)
    );

    wsc_trap_encode u_enc (
        .kind(kind), .other_nz(otherwin != '0), .wstate(wstate_q), .ttype(ttype_d)
    );

    // Hold the window-state register, loaded by its own request code.
    always_ff @(posedge clk) begin
        if (!rst_n)                               wstate_q <= '0;
        else if (req_valid && op == OP_SET_WSTATE) wstate_q <= req_data[5:0];
    end

    // Register the trap pulse and its number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid_q <= 1'b0;
            trap_type_q  <= '0;
        end else begin
            trap_valid_q <= (kind != TK_NONE);
            trap_type_q  <= ttype_d;
        end
    end

    assign trap_valid = trap_valid_q;
    assign trap_type  = trap_type_q;
    assign wstate     = wstate_q;

    p_trap_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_type[7] || trap_type == TT_CLEAN));
    p_trap_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !trap_valid);
    p_quiet_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_type == 9'h000));
endmodule

// File: tb/test_wsc_window_ctrl.sv
`timescale 1ns/1ps

// One build of the controller with its own stimulus and a behavioural
// reference model compared on every clock.
module wsc_lane #(parameter int NW = 8) (
    input  logic clk,
    output int   checks,
    output int   errs,
    output logic done
);
    localparam int CW = $clog2(NW);
    localparam int M  = (1 << CW) - 1;

    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_data = 8'd0;
    logic       trap_valid;
    logic [8:0] trap_type;
    logic [CW-1:0] cwp, cwp_sw, cansave, canrestore, cleanwin, otherwin;
    logic [5:0] wstate;

    wsc_window_ctrl #(.NWIN(NW), .DW(8)) i_wsc_window_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .trap_valid(trap_valid), .trap_type(trap_type),
        .cwp(cwp), .cwp_sw(cwp_sw), .cansave(cansave), .canrestore(canrestore),
        .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate)
    );

    int m_cs, m_cr, m_cl, m_ow, m_cp, m_ws, m_tt;
    bit m_tv;
    string tag = "R1";
    bit check_reset = 1'b0;

    function automatic int enc(int base, int ws, int ow);
        if (ow != 0) return base | 32 | (((ws >> 3) & 7) << 2);
        return base | ((ws & 7) << 2);
    endfunction

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        m_tv = 1'b0; m_tt = 0;
        if (!rst_n) begin
            m_cs = NW - 2; m_cr = 0; m_ow = 0; m_cl = NW - 1; m_cp = 0; m_ws = 0;
            tag = "R1";
        end else if (req_valid) begin
            case (req_op)
                3'd0: if (m_cs == 0) begin m_tv = 1; m_tt = enc(128, m_ws, m_ow); tag = "R2 R6"; end
                      else if (m_cl == m_cr) begin m_tv = 1; m_tt = 'h24; tag = "R3"; end
                      else begin m_cs = (m_cs - 1) & M; m_cr = (m_cr + 1) & M;
                                 m_cp = (m_cp + NW - 1) % NW; tag = "R4"; end
                3'd1: if (m_cr == 0) begin m_tv = 1; m_tt = enc(192, m_ws, m_ow); tag = "R5 R6"; end
                      else begin m_cs = (m_cs + 1) & M; m_cr = (m_cr - 1) & M;
                                 m_cp = (m_cp + 1) % NW; tag = "R5"; end
                3'd2: begin if (m_cs != NW - 2) begin m_tv = 1; m_tt = enc(128, m_ws, m_ow); end
                            tag = "R7"; end
                3'd3: begin m_cs = (m_cs + 1) & M;
                            if (m_ow != 0) m_ow = m_ow - 1; else m_cr = (m_cr - 1) & M;
                            tag = "R8"; end
                3'd4: begin m_cr = (m_cr + 1) & M;
                            if (m_cl < NW - 1) m_cl = m_cl + 1;
                            if (m_ow != 0) m_ow = m_ow - 1; else m_cs = (m_cs - 1) & M;
                            tag = "R9"; end
                3'd5: begin m_ws = req_data & 63; tag = "R11"; end
                3'd6: begin m_cp = NW - 1 - (req_data % NW); tag = "R10"; end
                default: begin m_ow = req_data & M; tag = "R11"; end
            endcase
        end else tag = "R6";
    end

    // Compare every observable output against the model, away from the edge.
    always @(negedge clk) begin
        if (check_reset) begin
            checks = checks + 1;
            if (cansave != CW'(NW - 2) || canrestore != 0 || otherwin != 0 ||
                cleanwin != CW'(NW - 1) || cwp != 0 || wstate != 0 || trap_valid || trap_type != 0) begin
                errs = errs + 1;
                $display("FAIL R1 N=%0d reset: cs=%0d cr=%0d cl=%0d ow=%0d cwp=%0d exp cs=%0d cr=0 cl=%0d ow=0 cwp=0",
                         NW, cansave, canrestore, cleanwin, otherwin, cwp, NW - 2, NW - 1);
            end
        end
        if (rst_n) begin
            checks = checks + 6;
            if (int'(cansave) != m_cs || int'(canrestore) != m_cr) begin
                errs = errs + 1;
                $display("FAIL %s N=%0d cs/cr: got %0d/%0d exp %0d/%0d", tag, NW, cansave, canrestore, m_cs, m_cr);
            end
            if (int'(cleanwin) != m_cl || int'(otherwin) != m_ow) begin
                errs = errs + 1;
                $display("FAIL %s N=%0d cl/ow: got %0d/%0d exp %0d/%0d", tag, NW, cleanwin, otherwin, m_cl, m_ow);
            end
            if (int'(cwp) != m_cp) begin
                errs = errs + 1;
                $display("FAIL %s N=%0d cwp: got %0d exp %0d", tag, NW, cwp, m_cp);
            end
            if (int'(cwp_sw) != NW - 1 - m_cp) begin
                errs = errs + 1;
                $display("FAIL R10 N=%0d cwp_sw: got %0d exp %0d", NW, cwp_sw, NW - 1 - m_cp);
            end
            if (int'(wstate) != m_ws) begin
                errs = errs + 1;
                $display("FAIL R11 N=%0d wstate: got %0d exp %0d", NW, wstate, m_ws);
            end
            if (trap_valid != m_tv || int'(trap_type) != m_tt) begin
                errs = errs + 1;
                $display("FAIL %s R6 N=%0d trap: got %0b/%03h exp %0b/%03h", tag, NW, trap_valid, trap_type, m_tv, m_tt);
            end
        end
    end

    task automatic put(input int op, input int data);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_data = 8'(data);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset = 1'b1;
        @(negedge clk);
        check_reset = 1'b0;
    endtask

    initial begin
        checks = 0; errs = 0; done = 1'b0;
        do_reset();
        // R6 R2 R4: fill the saves, then spill with otherwin zero.
        put(5, 'h2B);
        repeat (NW - 2) put(0, 0);
        put(0, 0);
        put(2, 0);                          // R7 flush with windows in use
        repeat (NW - 2) put(1, 0);          // R5 restores back to the start
        put(1, 0);                          // R5 fill
        put(2, 0);                          // R7 flush with no trap
        idle();
        // R6 trap numbers with otherwin nonzero.
        put(7, 2);
        repeat (NW) put(0, 0);
        put(1, 0);
        put(3, 0); put(3, 0); put(3, 0);    // R8
        put(4, 0);                          // R9
        idle();
        // R3 clean-window trap and R9 saturation.
        do_reset();
        put(7, NW - 1);
        repeat (NW - 1) put(4, 0);
        put(0, 0);
        put(4, 0);
        // R10 software pointer writes.
        put(6, 13); put(6, 0); put(6, NW - 1); put(6, 255);
        put(0, 0); put(1, 0);
        idle();
        // Mixed stream of requests.
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            if (r > 11) idle();
            else if (r > 7) put(r - 8, int'($urandom_range(0, 255)));
            else put(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
        end
        idle(); idle();
        done = 1'b1;
    end
endmodule

module test_wsc_window_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int   c8, e8, c5, e5;
    logic d8, d5;
    int   cycles = 0;

    wsc_lane #(.NW(8)) u_lane8 (.clk(clk), .checks(c8), .errs(e8), .done(d8));
    wsc_lane #(.NW(5)) u_lane5 (.clk(clk), .checks(c5), .errs(e5), .done(d5));

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        int wd_fail;
        wd_fail = 0;
        while (!(d8 === 1'b1 && d5 === 1'b1) && cycles < 100000) @(negedge clk);
        if (cycles >= 100000) begin
            wd_fail = 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles exp fewer", cycles);
        end
        $display("CHECKS %0d ERRORS %0d", c8 + c5 + wd_fail, e8 + e5 + wd_fail);
        $finish;
    end
endmodule